// File: doc/BRIEF.md
# Single-Frame Transmit Store

This block holds one outgoing CAN FD frame between the host and the protocol engine. The host fills it through a word-wide write port using a 5-bit word address. Words 0 to 3 form the frame header: word 0 carries format, DLC and frame type, words 1 and 2 carry the transmit time, and word 3 carries the identifier. Words 4 to 19 carry up to 64 data bytes. The header words sit in plain registers and are presented together as one 128-bit metadata vector. Arbitration logic can therefore inspect a pending frame without going through the RAM port. The data words sit in an inferred RAM that the protocol engine reads one word at a time through a 4-bit data index.

Ownership passes between the two sides through a level input `tx_allow`. While it is low, the host may edit the content. A rising edge hands the frame to the protocol side, which then sees `frame_valid` high and `frame_empty` low. When the engine has sent the frame, it pulses `sent_ack`. That raises `frame_empty` and invalidates the content, and the state holds until the host takes the buffer back and hands it over again. A build-time parameter selects a reduced store that keeps only the first two data words (8 bytes). In that build the DLC may still claim more, but every higher data index reads as zero.

Top module: `tx_frame_store`

## Requirements
- R1: A host write to word address 0, 1, 2 or 3 while `tx_allow` is 0 appears on `frame_meta` in bits [31:0], [63:32], [95:64] or [127:96] respectively, from the clock edge that accepts the write onward.
- R2: A host write to word address 4+k (k from 0 to 15) while `tx_allow` is 0 stores a data word that reads back at data index k.
- R3: `rd_word` shows the word selected by the `rd_idx` value sampled at a rising clock edge, from that edge until the next one, so the read latency is one cycle.
- R4: Host writes made while `tx_allow` is 1 are ignored, leaving both `frame_meta` and the stored data words unchanged.
- R5: A rising edge of `tx_allow` sets `frame_valid` to 1 and `frame_empty` to 0 on the next clock edge.
- R6: `sent_ack` sampled high while `frame_valid` is 1 sets `frame_empty` to 1 and `frame_valid` to 0 on the same edge. The block then stays empty while `tx_allow` remains 1.
- R7: When `tx_allow` is sampled 0, `frame_valid` is 0 after that clock edge.
- R8: After reset, `frame_empty` is 1, `frame_valid` is 0, `frame_meta` is all zeros and `rd_word` is zero.
- R9: With `FULL_SIZE` = 0, only data indices 0 and 1 are stored. A read at any index from 2 to 15 returns zero, and writes to those words have no effect.
- R10: Host writes to word addresses 20 to 31 change neither `frame_meta` nor any stored data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host word address (0..3 header, 4..19 data) |
| host_wdata | input | 32 | Host write data |
| tx_allow | input | 1 | Host hands the frame to the protocol side while high |
| sent_ack | input | 1 | Protocol side reports the frame as sent |
| rd_idx | input | 4 | Data word index from the protocol side |
| rd_word | output | 32 | Data word registered from `rd_idx` |
| frame_meta | output | 128 | The four header words, word 0 in the low bits |
| frame_valid | output | 1 | Content handed over and not yet sent |
| frame_empty | output | 1 | No frame pending for transmission |

## Verification
On every cycle, the assertions check the following: the header stays frozen while the buffer is handed over, an acknowledge of a valid frame empties it, a low `tx_allow` drops validity, a fresh hand-over loads it, and in the reduced build out-of-range indices read zero. Only the bench scenarios can show some other behaviours. These include whether the right word lands at the right index, whether locked or out-of-range writes leave the data RAM untouched, and whether the one-cycle read latency holds. They also include whether the empty state survives until a fresh hand-over, and the full contrast between the two size builds.

// File: rtl/tx_frame_store.sv
module tx_frame_store #(
  parameter bit FULL_SIZE = 1'b1,
  parameter int WORD_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [4:0]          host_addr,
  input  logic [WORD_W-1:0]   host_wdata,
  input  logic                tx_allow,
  input  logic                sent_ack,
  input  logic [3:0]          rd_idx,
  output logic [WORD_W-1:0]   rd_word,
  output logic [4*WORD_W-1:0] frame_meta,
  output logic                frame_valid,
  output logic                frame_empty
);
  localparam int HDR_WORDS  = 4;
  localparam int DATA_WORDS = FULL_SIZE ? 16 : 2;
  localparam int AW         = $clog2(DATA_WORDS);

  logic [WORD_W-1:0] hdr [HDR_WORDS];
  logic [WORD_W-1:0] data_mem [DATA_WORDS];
  logic              allow_d;
  logic              loaded;
  logic [4:0]        doff;
  logic              wr_ok, hdr_hit, data_hit, rd_in_range;

  assign wr_ok       = host_we && !tx_allow;
  assign doff        = host_addr - 5'(HDR_WORDS);
  assign hdr_hit     = int'(host_addr) < HDR_WORDS;
  assign data_hit    = !hdr_hit && (int'(doff) < DATA_WORDS);
  assign rd_in_range = int'(rd_idx) < DATA_WORDS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HDR_WORDS; i++) hdr[i] <= '0;
    end else if (wr_ok && hdr_hit) begin
      hdr[host_addr[1:0]] <= host_wdata;
    end
  end

  generate
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_meta
      assign frame_meta[g*WORD_W +: WORD_W] = hdr[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_ok && data_hit) data_mem[doff[AW-1:0]] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rd_word <= '0;
    else if (rd_in_range) rd_word <= data_mem[rd_idx[AW-1:0]];
    else                  rd_word <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_d <= 1'b0;
      loaded  <= 1'b0;
    end else begin
      allow_d <= tx_allow;
      if (!tx_allow)      loaded <= 1'b0;
      else if (sent_ack)  loaded <= 1'b0;
      else if (!allow_d)  loaded <= 1'b1;
    end
  end

  assign frame_valid = loaded;
  assign frame_empty = !loaded;
endmodule

module tx_frame_store_chk #(
  parameter bit FULL_SIZE = 1'b1,
  parameter int WORD_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_we,
  input logic [4:0]          host_addr,
  input logic [WORD_W-1:0]   host_wdata,
  input logic                tx_allow,
  input logic                sent_ack,
  input logic [3:0]          rd_idx,
  input logic [WORD_W-1:0]   rd_word,
  input logic [4*WORD_W-1:0] frame_meta,
  input logic                frame_valid,
  input logic                frame_empty
);
  localparam int DATA_WORDS = FULL_SIZE ? 16 : 2;

  AST_META_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_allow |=> $stable(frame_meta)); // R4
  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && sent_ack) |=> (frame_empty && !frame_valid)); // R6
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_allow |=> !frame_valid); // R7
  AST_HANDOVER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_allow) && !sent_ack) |=> (frame_valid && !frame_empty)); // R5
  AST_SMALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= DATA_WORDS) |=> (rd_word == '0)); // R9
endmodule

bind tx_frame_store tx_frame_store_chk #(.FULL_SIZE(FULL_SIZE), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/tx_frame_store_bench.sv
module tx_frame_store_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd0,  32'h1111_0000}, {4'd1,  32'h2222_0001}, {4'd2,  32'h3333_0002},
    {4'd7,  32'h7777_0007}, {4'd15, 32'hFFFF_000F}, {4'd9,  32'h9999_0009}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0, tx_allow = 1'b0, sent_ack = 1'b0;
  logic [4:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [3:0] rd_idx = '0;
  logic [31:0] rd_f, rd_s;
  logic [127:0] meta_f, meta_s;
  logic val_f, val_s, emp_f, emp_s;
  int checks = 0, failures = 0;
  logic [127:0] exp_meta;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_frame_store u_tx_frame_store (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .tx_allow, .sent_ack, .rd_idx,
    .rd_word(rd_f), .frame_meta(meta_f), .frame_valid(val_f), .frame_empty(emp_f));

  tx_frame_store #(.FULL_SIZE(1'b0)) u_tx_frame_store_small (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .tx_allow, .sent_ack, .rd_idx,
    .rd_word(rd_s), .frame_meta(meta_s), .frame_valid(val_s), .frame_empty(emp_s));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i);
    @(negedge clk); rd_idx = i;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 empty", {127'd0, emp_f}, 128'd1);
    chk("R8 valid", {127'd0, val_f}, 128'd0);
    chk("R8 meta", meta_f, 128'd0);
    chk("R8 rd_word", {96'd0, rd_f}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) wr(5'(i), 32'hA0A0_0000 + i);
    exp_meta = {32'hA0A0_0003, 32'hA0A0_0002, 32'hA0A0_0001, 32'hA0A0_0000};
    chk("R1 meta full", meta_f, exp_meta);
    chk("R1 meta small", meta_s, exp_meta);

    for (int v = 0; v < NVEC; v++) wr(5'(VEC[v][35:32]) + 5'd4, VEC[v][31:0]);
    for (int v = 0; v < NVEC; v++) begin
      rd(VEC[v][35:32]);
      chk("R2 full read", {96'd0, rd_f}, {96'd0, VEC[v][31:0]});
      chk("R9 small read", {96'd0, rd_s},
          {96'd0, (VEC[v][35:32] < 4'd2) ? VEC[v][31:0] : 32'd0});
    end

    rd(4'd0);
    @(negedge clk); rd_idx = 4'd1;
    #1 chk("R3 before edge", {96'd0, rd_f}, {96'd0, 32'h1111_0000});
    @(negedge clk);
    chk("R3 after edge", {96'd0, rd_f}, {96'd0, 32'h2222_0001});

    wr(5'd20, 32'hDEAD_0020);
    wr(5'd31, 32'hDEAD_001F);
    chk("R10 meta", meta_f, exp_meta);
    rd(4'd0);
    chk("R10 data0", {96'd0, rd_f}, {96'd0, 32'h1111_0000});

    @(negedge clk); tx_allow = 1'b1;
    @(negedge clk);
    chk("R5 valid", {127'd0, val_f}, 128'd1);
    chk("R5 empty", {127'd0, emp_f}, 128'd0);

    wr(5'd0, 32'hBAD0_BAD0);
    wr(5'd4, 32'hBAD1_BAD1);
    chk("R4 meta", meta_f, exp_meta);
    rd(4'd0);
    chk("R4 data", {96'd0, rd_f}, {96'd0, 32'h1111_0000});

    @(negedge clk); sent_ack = 1'b1;
    @(negedge clk); sent_ack = 1'b0;
    chk("R6 empty", {127'd0, emp_f}, 128'd1);
    chk("R6 valid", {127'd0, val_f}, 128'd0);
    repeat (2) @(negedge clk);
    chk("R6 stays empty", {127'd0, emp_f}, 128'd1);

    tx_allow = 1'b0;
    @(negedge clk); tx_allow = 1'b1;
    @(negedge clk);
    chk("R5 reload", {127'd0, val_s}, 128'd1);
    tx_allow = 1'b0;
    @(negedge clk);
    chk("R7 valid drop", {127'd0, val_f}, 128'd0);
    chk("R7 empty", {127'd0, emp_f}, 128'd1);

    finish_run();
  end
endmodule